// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog for a system-on-chip. Software sets a reload value and a prescale factor through a small word-wide register port, then turns the timer on. Each decrement of the countdown waits for a set number of microsecond ticks from a free-running 1 MHz strobe. If software fails to restart the countdown in time, the counter reaches zero and the block raises a reset request for a fixed number of clocks. After that the counter stays parked at zero until software reloads it.

A sticky cause flag records that the watchdog fired. It sits on the power-on reset only, so it survives the system reset that the request triggers. Boot code reads the flag to find out why the chip restarted, and clears it by writing a one. The enable bit reads back, so a loader can tell whether the timer is already running. Software can stop it, reprogram the prescale and reload values, and restart it without a spurious expiry.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control (0x20) reads 0x00000000, reload (0x24) reads 0x0000FFFF, restart (0x00) reads 0, cause (0x38) reads 0 after power-on reset, and `wdt_rst_req` is low.
- R2: The control word holds the enable in bit 7 and the prescale in bits 31:16. The reload word holds the count in bits 15:0. Every other bit of every register reads as zero, and the enable bit reads back as written.
- R3: Writing a word with bit 9 set to offset 0x00 loads the counter from the reload register and restarts the prescale phase from zero. This works whether the timer is enabled or not.
- R4: While enabled, the counter drops by one after every P microsecond ticks, where P is the prescale field. While disabled, the counter holds and the prescale phase is cleared.
- R5: When a decrement takes the counter from 1 to 0, `wdt_rst_req` goes high in the next cycle and stays high for exactly PULSE_CYCLES clocks (16 by default). The counter then stays at zero and never fires again until a restart.
- R6: A prescale field of 0 behaves as a factor of 1.
- R7: A write to offset 0x00 with bit 9 clear has no effect on the countdown.
- R8: Bit 1 of the cause register (0x38) is set by an expiry and is unaffected by `sys_rst_n`. It is cleared by `por_n` or by writing 1 to bit 1; writing 0 leaves it set.
- R9: Stopping the timer, writing a new prescale and reload value, restarting and enabling again gives a full new period with no early expiry.
- R10: A restart in the same cycle as the final decrement tick wins: no expiry occurs and the counter takes the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears only the cause flag |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; clears everything except the cause flag |
| us_tick | input | 1 | One-clock strobe at 1 MHz |
| reg_addr | input | AW | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| wdt_rst_req | output | 1 | Reset request pulse to the system reset controller |

## Verification
The bench places restarts part way through a prescale period. A design that kept the old phase would expire one tick early. It also lands a restart on the exact edge of the final tick, where a design that let the tick win would fire despite the restart. It keeps ticking after an expiry to catch a counter that wraps and fires a second time. It pauses the timer mid-period to catch a phase that leaks across a disable. Finally, it pulses the system reset and the power-on reset on their own, to show that the cause flag follows only the latter.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    // Register byte offsets
    localparam int unsigned OFS_RESTART = 'h00;
    localparam int unsigned OFS_CTRL    = 'h20;
    localparam int unsigned OFS_RELOAD  = 'h24;
    localparam int unsigned OFS_CAUSE   = 'h38;

    // Bit positions
    localparam int unsigned BIT_RESTART = 9;
    localparam int unsigned BIT_ENABLE  = 7;
    localparam int unsigned PSC_LSB     = 16;
    localparam int unsigned BIT_CAUSE   = 1;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned PSC_W       = WORD_W - PSC_LSB;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs #(
    parameter int unsigned AW    = 8,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_wr,
    input  logic [31:0]      reg_wdata,
    input  logic             cause_flag,
    output logic             run_en,
    output logic [PSC_W-1:0] psc,
    output logic [CNT_W-1:0] reload_val,
    output logic             restart,
    output logic             cause_clr,
    output logic [31:0]      reg_rdata
);
    import wdog_pkg::*;

    typedef struct packed {
        logic             en;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t r_d, r_q;

    logic hit_restart, hit_ctrl, hit_reload, hit_cause;

    always_comb begin
        hit_restart = (reg_addr == AW'(OFS_RESTART));
        hit_ctrl    = (reg_addr == AW'(OFS_CTRL));
        hit_reload  = (reg_addr == AW'(OFS_RELOAD));
        hit_cause   = (reg_addr == AW'(OFS_CAUSE));

        r_d = r_q;
        if (reg_wr && hit_ctrl) begin
            r_d.en  = reg_wdata[BIT_ENABLE];
            r_d.psc = reg_wdata[PSC_LSB +: PSC_W];
        end
        if (reg_wr && hit_reload) begin
            r_d.reload = reg_wdata[CNT_W-1:0];
        end

        restart   = reg_wr && hit_restart && reg_wdata[BIT_RESTART];
        cause_clr = reg_wr && hit_cause && reg_wdata[BIT_CAUSE];

        reg_rdata = '0;
        if (hit_ctrl) begin
            reg_rdata[BIT_ENABLE]          = r_q.en;
            reg_rdata[PSC_LSB +: PSC_W]    = r_q.psc;
        end else if (hit_reload) begin
            reg_rdata[CNT_W-1:0]           = r_q.reload;
        end else if (hit_cause) begin
            reg_rdata[BIT_CAUSE]           = cause_flag;
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            r_q.en     <= 1'b0;
            r_q.psc    <= '0;
            r_q.reload <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_en     = r_q.en;
    assign psc        = r_q.psc;
    assign reload_val = r_q.reload;
endmodule

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             us_tick,
    input  logic             run_en,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             step
);
    typedef struct packed {
        logic [PSC_W-1:0] phase;
    } psc_state_t;

    psc_state_t s_d, s_q;

    logic [PSC_W-1:0] period;
    logic [PSC_W:0]   phase_inc;

    always_comb begin
        s_d       = s_q;
        step      = 1'b0;
        period    = (psc == '0) ? PSC_W'(1) : psc;
        phase_inc = {1'b0, s_q.phase} + (PSC_W+1)'(1);
        if (restart || !run_en) begin
            s_d.phase = '0;
        end else if (us_tick) begin
            // >= keeps a shrunken prescale from running the phase past it
            if (phase_inc >= {1'b0, period}) begin
                step      = 1'b1;
                s_d.phase = '0;
            end else begin
                s_d.phase = phase_inc[PSC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) s_q <= '0;
        else            s_q <= s_d;
    end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic             clk,
    input  logic             sys_rst_n,
    input  logic             step,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             rst_req
);
    localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PW-1:0]    pulse;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = step && !reload && (s_q.cnt == CNT_W'(1));

        if (reload) begin
            s_d.cnt = reload_val;
        end else if (step && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end

        if (expire) begin
            s_d.pulse = PW'(PULSE_CYCLES);
        end else if (s_q.pulse != '0) begin
            s_d.pulse = s_q.pulse - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            s_q.cnt   <= '1;
            s_q.pulse <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count   = s_q.cnt;
    assign rst_req = (s_q.pulse != '0);

    // R5: each request lasts a full window once started
    p_pulse_hold_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ($rose(rst_req) && !expire) |=> rst_req);
endmodule

// File: rtl/wdog_cause.sv
`timescale 1ns/1ps
module wdog_cause (
    input  logic clk,
    input  logic por_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic hit;
    } cause_state_t;

    cause_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (set)      s_d.hit = 1'b1;
        else if (clr) s_d.hit = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag = s_q.hit;

    // R8: an expiry always leaves the flag set
    p_cause_sets_r8: assert property (@(posedge clk) disable iff (!por_n)
        set |=> flag);
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer #(
    parameter int unsigned AW           = 8,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          sys_rst_n,
    input  logic          us_tick,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          wdt_rst_req
);
    import wdog_pkg::*;

    logic             run_en_w;
    logic [PSC_W-1:0] psc_w;
    logic [CNT_W-1:0] reload_w;
    logic             restart_w;
    logic             cause_clr_w;
    logic             cause_w;
    logic             step_w;
    logic [CNT_W-1:0] count_w;
    logic             expire_w;

    wdog_regs #(.AW(AW), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk        (clk),
        .sys_rst_n  (sys_rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .cause_flag (cause_w),
        .run_en     (run_en_w),
        .psc        (psc_w),
        .reload_val (reload_w),
        .restart    (restart_w),
        .cause_clr  (cause_clr_w),
        .reg_rdata  (reg_rdata)
    );

    wdog_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .us_tick   (us_tick),
        .run_en    (run_en_w),
        .restart   (restart_w),
        .psc       (psc_w),
        .step      (step_w)
    );

    wdog_counter #(.CNT_W(CNT_W), .PULSE_CYCLES(PULSE_CYCLES)) u_cnt (
        .clk        (clk),
        .sys_rst_n  (sys_rst_n),
        .step       (step_w),
        .reload     (restart_w),
        .reload_val (reload_w),
        .count      (count_w),
        .expire     (expire_w),
        .rst_req    (wdt_rst_req)
    );

    wdog_cause u_cause (
        .clk   (clk),
        .por_n (por_n),
        .set   (expire_w),
        .clr   (cause_clr_w),
        .flag  (cause_w)
    );

    // R3: a restart loads the programmed reload value
    p_restart_loads_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        restart_w |=> (count_w == $past(reload_w)));

    // R4: a disabled timer does not move
    p_freeze_when_off_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (!run_en_w && !restart_w) |=> $stable(count_w));

    // R5: an expiry raises the request on the next cycle
    p_request_follows_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        expire_w |=> wdt_rst_req);

    // R5: a parked counter never fires again
    p_parked_silent_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (count_w == '0) |-> !expire_w);

    // R10: restart beats a coinciding final tick
    p_restart_wins_r10: assert property (@(posedge clk) disable iff (!sys_rst_n)
        restart_w |-> !expire_w);
endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
    localparam int unsigned AW    = 8;
    localparam int unsigned PULSE = 16;

    logic          clk = 1'b0;
    logic          por_n;
    logic          sys_rst_n;
    logic          us_tick;
    logic [AW-1:0] reg_addr;
    logic          reg_wr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          wdt_rst_req;

    always #2 clk = ~clk;

    wdog_timer #(.AW(AW), .CNT_W(16), .PULSE_CYCLES(PULSE)) u_wdog_timer (
        .clk         (clk),
        .por_n       (por_n),
        .sys_rst_n   (sys_rst_n),
        .us_tick     (us_tick),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .wdt_rst_req (wdt_rst_req)
    );

    typedef struct {
        bit          is_read;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sb_ev;
    int       n_checks = 0;
    int       n_fail   = 0;
    bit       done     = 0;

    // Monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_read ? reg_rdata : {31'b0, wdt_rst_req};
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    function automatic logic [31:0] ctrl_word(input int unsigned p, input bit en);
        return (32'(p) << 16) | (en ? 32'h80 : 32'h0);
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        reg_addr = a;
        #1;
        it.is_read = 1'b1; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        ->sb_ev;
    endtask

    task automatic req_chk(input bit e, input string tag);
        sb_item_t it;
        #1;
        it.is_read = 1'b0; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        ->sb_ev;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); us_tick = 1'b1;
            @(negedge clk); us_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic arm(input int unsigned p, input logic [15:0] ld);
        wr(8'h20, ctrl_word(p, 1'b0));
        wr(8'h24, {16'h0, ld});
        wr(8'h00, 32'h200);
        wr(8'h20, ctrl_word(p, 1'b1));
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; sys_rst_n = 1'b0; us_tick = 1'b0;
        reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        idle(3);
        por_n = 1'b1; sys_rst_n = 1'b1;

        // R1 reset state
        rd_chk(8'h20, 32'h0, "R1 ctrl");
        rd_chk(8'h24, 32'h0000FFFF, "R1 reload");
        rd_chk(8'h00, 32'h0, "R1 restart reg");
        rd_chk(8'h38, 32'h0, "R1 cause");
        req_chk(1'b0, "R1 request low");

        // R2 field layout, unused bits zero
        wr(8'h20, 32'hFFFFFF7F);
        rd_chk(8'h20, 32'hFFFF0000, "R2 ctrl fields");
        wr(8'h24, 32'hFFFFFFFF);
        rd_chk(8'h24, 32'h0000FFFF, "R2 reload field");
        wr(8'h00, 32'hFFFFFDFF);
        rd_chk(8'h00, 32'h0, "R2 restart reads zero");

        // R3/R4/R5: prescale 3, reload 2 -> expiry on tick 6
        arm(3, 16'd2);
        rd_chk(8'h20, 32'h00030080, "R2 enable readback");
        ticks(5);  req_chk(1'b0, "R4 before expiry");
        ticks(1);  req_chk(1'b1, "R5 expiry raises request");
        idle(PULSE-1); req_chk(1'b1, "R5 pulse still high");
        idle(1);   req_chk(1'b0, "R5 pulse length");
        ticks(10); req_chk(1'b0, "R5 parked at zero");
        rd_chk(8'h38, 32'h2, "R8 cause set");

        // R8: system reset keeps cause, clears the rest
        @(negedge clk); sys_rst_n = 1'b0;
        idle(2); sys_rst_n = 1'b1;
        rd_chk(8'h38, 32'h2, "R8 cause survives system reset");
        rd_chk(8'h20, 32'h0, "R1 ctrl after system reset");
        wr(8'h38, 32'h0);
        rd_chk(8'h38, 32'h2, "R8 write zero keeps cause");
        wr(8'h38, 32'h2);
        rd_chk(8'h38, 32'h0, "R8 write one clears cause");

        // R3: restart mid-period clears the prescale phase
        arm(4, 16'd1);
        ticks(3);
        wr(8'h00, 32'h200);
        ticks(3); req_chk(1'b0, "R3 phase cleared by restart");
        ticks(1); req_chk(1'b1, "R3 full period after restart");
        idle(PULSE+2);

        // R4: disable freezes and clears phase
        arm(2, 16'd2);
        ticks(3);
        wr(8'h20, ctrl_word(2, 1'b0));
        ticks(10); req_chk(1'b0, "R4 frozen while disabled");
        wr(8'h20, ctrl_word(2, 1'b1));
        ticks(1); req_chk(1'b0, "R4 phase restarted on enable");
        ticks(1); req_chk(1'b1, "R4 resumes count");
        idle(PULSE+2);

        // R6: prescale zero acts as one
        arm(0, 16'd3);
        ticks(2); req_chk(1'b0, "R6 before expiry");
        ticks(1); req_chk(1'b1, "R6 one tick per step");
        idle(PULSE+2);

        // R7: restart write without bit 9 is ignored
        arm(1, 16'd3);
        ticks(2);
        wr(8'h00, 32'hFFFFFDFF);
        ticks(1); req_chk(1'b1, "R7 write without bit 9 ignored");
        idle(PULSE+2);

        // R3: restart while disabled still loads the counter
        ticks(5); req_chk(1'b0, "R5 no refire when parked");
        wr(8'h20, ctrl_word(1, 1'b0));
        wr(8'h24, 32'd2);
        wr(8'h00, 32'h200);
        wr(8'h20, ctrl_word(1, 1'b1));
        ticks(1); req_chk(1'b0, "R3 disabled restart count");
        ticks(1); req_chk(1'b1, "R3 restart while disabled");
        idle(PULSE+2);

        // R10: restart on the final tick wins
        arm(1, 16'd2);
        ticks(1);
        @(negedge clk);
        us_tick = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h200; reg_wr = 1'b1;
        @(negedge clk);
        us_tick = 1'b0; reg_wr = 1'b0;
        req_chk(1'b0, "R10 restart beats final tick");
        ticks(1); req_chk(1'b0, "R10 counter reloaded");
        ticks(1); req_chk(1'b1, "R10 expiry after reload");
        idle(PULSE+2);

        // R9: reconfigure a running timer
        arm(2, 16'd3);
        ticks(5);
        wr(8'h00, 32'h200);
        wr(8'h20, ctrl_word(2, 1'b0));
        wr(8'h20, ctrl_word(5, 1'b0));
        wr(8'h24, 32'd2);
        wr(8'h00, 32'h200);
        wr(8'h20, ctrl_word(5, 1'b1));
        req_chk(1'b0, "R9 no expiry on reconfigure");
        ticks(9); req_chk(1'b0, "R9 full new period");
        ticks(1); req_chk(1'b1, "R9 expiry at new period");
        idle(PULSE+2);

        // R8: power-on reset clears cause
        rd_chk(8'h38, 32'h2, "R8 cause set again");
        @(negedge clk); por_n = 1'b0;
        idle(2); por_n = 1'b1;
        rd_chk(8'h38, 32'h0, "R8 power-on clears cause");

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule